// File: doc/BRIEF.md
# Multi-context NIC descriptor dispatcher

This block is the register front end of a network interface shared by up to sixteen software contexts. Each bus access carries an address whose upper bits pick a context and whose lower bits pick a register inside that context's window. The block checks every access against a small table of registers (offset, allowed direction, access size). It keeps, per context, a receive descriptor word, a receive status word, a transmit descriptor word and a transmit status word. Every request gets a registered one-cycle response: an acknowledge pulse on success or an error pulse on failure.

A successful descriptor write marks the context busy and queues its index on an ordered receive or transmit service list. It also kicks the matching engine when that engine can take work. The engines drain the lists through pop strobes. They see the head context and its descriptor, and they write completion status words back per context. Status reads overlay live FIFO information on the stored word.

Top module: `nic_ctx_dispatch`

## Requirements
- R1: The context index is addr_i[CTX_SHIFT+CTX_W-1:CTX_SHIFT] and the register offset is addr_i[CTX_SHIFT-1:0]. One cycle after req_i, exactly one of ack_o or err_o pulses for one cycle. Neither pulses without a request. Offset 0x20 is a read-only 4-byte info word: bits [CTX_W-1:0] hold the context index, bit 16 holds the receive busy bit and bit 17 holds the transmit busy bit.
- R2: An offset outside the table (0x00 rx descriptor, 0x08 rx status, 0x10 tx descriptor, 0x18 tx status, 0x20 info) gives err_o.
- R3: Writing a read-only register (the two status words, the info word) gives err_o and leaves all register state unchanged.
- R4: size8_i=1 marks an 8-byte access and size8_i=0 a 4-byte access. The descriptors and status words are 8 bytes and the info word is 4 bytes. Any mismatch gives err_o.
- R5: A write to the rx descriptor gives err_o when the context's receive busy bit (rx status bit 63) is set. Otherwise the rx status word becomes exactly bit 63, the descriptor is stored (readable at offset 0x00) and the index is appended to the receive list.
- R6: A write to the tx descriptor gives err_o when tx status bit 63 is set. Otherwise the word is stored, bit 63 is set, and the index is appended only if the transmit list is empty or its head holds a different index.
- R7: rx_kick_o pulses together with the acknowledge of an accepted rx descriptor write, and only when rx_en_i and rx_idle_i are both high.
- R8: tx_kick_o pulses with the acknowledge of an accepted tx descriptor write, and only when tx_en_i and tx_idle_i are high and the head of the transmit list is that context after the write.
- R9: A status read returns the stored word with bits [55:48] replaced by the live packet count saturated at 255 (rx_pkts_i for receive, tx_pkts_i for transmit).
- R10: A tx status read sets bit 61 when tx_free_i < tx_max_copy_i and bit 60 when tx_level_i < tx_mark_i. Both bits are cleared otherwise.
- R11: Each list is first in, first out. A pop strobe removes the head. The *_q_vld_o, *_q_ctx_o and *_q_desc_o outputs show the head, its index and its stored descriptor.
- R12: A write that would push into a full list gives err_o together with ovf_o, and stores nothing.
- R13: An engine completion write (*_dn_we_i) replaces the addressed context's status word, which clears its busy bit when bit 63 of the new word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| size8_i | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| addr_i | input | CTX_SHIFT+CTX_W | Context index and register offset |
| wdata_i | input | 64 | Write data |
| ack_o | output | 1 | Successful access pulse |
| err_o | output | 1 | Access error pulse |
| ovf_o | output | 1 | List overflow pulse, with err_o |
| rdata_o | output | 64 | Read data, valid with ack_o |
| rx_en_i | input | 1 | Receive enabled |
| rx_idle_i | input | 1 | Receive engine idle |
| tx_en_i | input | 1 | Transmit enabled |
| tx_idle_i | input | 1 | Transmit engine idle |
| rx_kick_o | output | 1 | Start pulse to the receive engine |
| tx_kick_o | output | 1 | Start pulse to the transmit engine |
| rx_q_pop_i | input | 1 | Receive engine removes list head |
| rx_q_vld_o | output | 1 | Receive list not empty |
| rx_q_ctx_o | output | CTX_W | Receive list head index |
| rx_q_desc_o | output | 64 | Rx descriptor of head context |
| tx_q_pop_i | input | 1 | Transmit engine removes list head |
| tx_q_vld_o | output | 1 | Transmit list not empty |
| tx_q_ctx_o | output | CTX_W | Transmit list head index |
| tx_q_desc_o | output | 64 | Tx descriptor of head context |
| rx_dn_we_i | input | 1 | Receive completion write |
| rx_dn_ctx_i | input | CTX_W | Context of receive completion |
| rx_dn_word_i | input | 64 | New receive status word |
| tx_dn_we_i | input | 1 | Transmit completion write |
| tx_dn_ctx_i | input | CTX_W | Context of transmit completion |
| tx_dn_word_i | input | 64 | New transmit status word |
| rx_pkts_i | input | CNT_W | Live receive FIFO packet count |
| tx_pkts_i | input | CNT_W | Live transmit FIFO packet count |
| tx_free_i | input | CNT_W | Free transmit FIFO space |
| tx_level_i | input | CNT_W | Transmit FIFO occupancy |
| tx_max_copy_i | input | CNT_W | Maximum copy size |
| tx_mark_i | input | CNT_W | Transmit low watermark |

## Verification
The assertions assume a clean engine interface. A pop strobe is treated as honest only when it follows the list's own valid output, and a completion write never lands in the same cycle as a bus descriptor write to the same context. They also assume that at most one request is issued per cycle with stable fields. The stimulus keeps to these rules. Every access is a single-cycle request driven between clock edges. Engine pops and completion writes are issued in cycles with no bus request. The overflow case is driven into a second instance built with a two-entry list. The bus is shared, so that instance also sees pops while its list is empty, and the list must ignore them.

// File: rtl/nic_ctx_pkg.sv
package nic_ctx_pkg;
  typedef enum logic [2:0] {
    SEL_RXD, SEL_RXS, SEL_TXD, SEL_TXS, SEL_INFO, SEL_NONE
  } reg_sel_e;

  localparam int unsigned BUSY_BIT   = 63;
  localparam int unsigned TXFULL_BIT = 61;
  localparam int unsigned TXLOW_BIT  = 60;
  localparam int unsigned CNT_LSB    = 48;
  localparam int unsigned RXB_INFO   = 16;
  localparam int unsigned TXB_INFO   = 17;

  function automatic logic [7:0] sat8(input logic [31:0] v);
    return (v > 32'd255) ? 8'hff : v[7:0];
  endfunction
endpackage

// File: rtl/nic_ctx_decode.sv
module nic_ctx_decode
  import nic_ctx_pkg::*;
#(
  parameter int unsigned OFF_W = 6
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic             we_i,
  input  logic             size8_i,
  output reg_sel_e         sel_o,
  output logic             ok_o
);
  logic rd_ok, wr_ok, is8;

  always_comb begin
    sel_o = SEL_NONE;
    rd_ok = 1'b0;
    wr_ok = 1'b0;
    is8   = 1'b1;
    if (off_i == OFF_W'(8'h00)) begin
      sel_o = SEL_RXD; rd_ok = 1'b1; wr_ok = 1'b1;
    end else if (off_i == OFF_W'(8'h08)) begin
      sel_o = SEL_RXS; rd_ok = 1'b1;
    end else if (off_i == OFF_W'(8'h10)) begin
      sel_o = SEL_TXD; rd_ok = 1'b1; wr_ok = 1'b1;
    end else if (off_i == OFF_W'(8'h18)) begin
      sel_o = SEL_TXS; rd_ok = 1'b1;
    end else if (off_i == OFF_W'(8'h20)) begin
      sel_o = SEL_INFO; rd_ok = 1'b1; is8 = 1'b0;
    end
    ok_o = (sel_o != SEL_NONE) && (we_i ? wr_ok : rd_ok) && (size8_i == is8);
  end
endmodule

// File: rtl/nic_ctx_queue.sv
module nic_ctx_queue #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic         full_o,
  output logic         vld_o,
  output logic [W-1:0] head_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = PW + 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign vld_o   = (cnt_q != '0);
  assign head_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && vld_o;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= din_i;
        wr_q        <= nxt(wr_q);
      end
      if (do_pop) rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/nic_ctx_dispatch.sv
module nic_ctx_dispatch
  import nic_ctx_pkg::*;
#(
  parameter int unsigned CTX_W     = 4,
  parameter int unsigned CTX_SHIFT = 6,
  parameter int unsigned Q_DEPTH   = 16,
  parameter int unsigned CNT_W     = 16,
  localparam int unsigned ADDR_W   = CTX_SHIFT + CTX_W,
  localparam int unsigned N_CTX    = 1 << CTX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              size8_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [63:0]       wdata_i,
  output logic              ack_o,
  output logic              err_o,
  output logic              ovf_o,
  output logic [63:0]       rdata_o,
  input  logic              rx_en_i,
  input  logic              rx_idle_i,
  input  logic              tx_en_i,
  input  logic              tx_idle_i,
  output logic              rx_kick_o,
  output logic              tx_kick_o,
  input  logic              rx_q_pop_i,
  output logic              rx_q_vld_o,
  output logic [CTX_W-1:0]  rx_q_ctx_o,
  output logic [63:0]       rx_q_desc_o,
  input  logic              tx_q_pop_i,
  output logic              tx_q_vld_o,
  output logic [CTX_W-1:0]  tx_q_ctx_o,
  output logic [63:0]       tx_q_desc_o,
  input  logic              rx_dn_we_i,
  input  logic [CTX_W-1:0]  rx_dn_ctx_i,
  input  logic [63:0]       rx_dn_word_i,
  input  logic              tx_dn_we_i,
  input  logic [CTX_W-1:0]  tx_dn_ctx_i,
  input  logic [63:0]       tx_dn_word_i,
  input  logic [CNT_W-1:0]  rx_pkts_i,
  input  logic [CNT_W-1:0]  tx_pkts_i,
  input  logic [CNT_W-1:0]  tx_free_i,
  input  logic [CNT_W-1:0]  tx_level_i,
  input  logic [CNT_W-1:0]  tx_max_copy_i,
  input  logic [CNT_W-1:0]  tx_mark_i
);
  logic [CTX_W-1:0]     ctx;
  logic [CTX_SHIFT-1:0] off;
  reg_sel_e             sel;
  logic                 acc_ok;

  logic [63:0] rxd_q [N_CTX];
  logic [63:0] rxs_q [N_CTX];
  logic [63:0] txd_q [N_CTX];
  logic [63:0] txs_q [N_CTX];

  logic rx_full, tx_full;
  logic rx_busy, tx_busy;
  logic rx_wr, tx_wr, rx_go, tx_go, rx_push, tx_push;
  logic tx_need_push, tx_ovf, tx_head_mine, err_c;
  logic [63:0] rd_word;

  assign ctx = addr_i[ADDR_W-1:CTX_SHIFT];
  assign off = addr_i[CTX_SHIFT-1:0];

  nic_ctx_decode #(.OFF_W(CTX_SHIFT)) i_decode (
    .off_i  (off),
    .we_i   (we_i),
    .size8_i(size8_i),
    .sel_o  (sel),
    .ok_o   (acc_ok)
  );

  nic_ctx_queue #(.DEPTH(Q_DEPTH), .W(CTX_W)) i_rx_q (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .push_i(rx_push),
    .din_i (ctx),
    .pop_i (rx_q_pop_i),
    .full_o(rx_full),
    .vld_o (rx_q_vld_o),
    .head_o(rx_q_ctx_o)
  );

  nic_ctx_queue #(.DEPTH(Q_DEPTH), .W(CTX_W)) i_tx_q (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .push_i(tx_push),
    .din_i (ctx),
    .pop_i (tx_q_pop_i),
    .full_o(tx_full),
    .vld_o (tx_q_vld_o),
    .head_o(tx_q_ctx_o)
  );

  assign rx_q_desc_o = rxd_q[rx_q_ctx_o];
  assign tx_q_desc_o = txd_q[tx_q_ctx_o];

  // request qualification
  assign rx_busy      = rxs_q[ctx][BUSY_BIT];
  assign tx_busy      = txs_q[ctx][BUSY_BIT];
  assign rx_wr        = req_i && we_i && acc_ok && (sel == SEL_RXD);
  assign tx_wr        = req_i && we_i && acc_ok && (sel == SEL_TXD);
  assign tx_head_mine = tx_q_vld_o && (tx_q_ctx_o == ctx);
  assign tx_need_push = !tx_head_mine;
  assign tx_ovf       = tx_need_push && tx_full;
  assign rx_go        = rx_wr && !rx_busy && !rx_full;
  assign tx_go        = tx_wr && !tx_busy && !tx_ovf;
  assign rx_push      = rx_go;
  assign tx_push      = tx_go && tx_need_push;
  assign err_c        = req_i && (!acc_ok || (rx_wr && !rx_go) || (tx_wr && !tx_go));

  always_comb begin
    rd_word = '0;
    unique case (sel)
      SEL_RXD: rd_word = rxd_q[ctx];
      SEL_TXD: rd_word = txd_q[ctx];
      SEL_RXS: begin
        rd_word = rxs_q[ctx];
        rd_word[CNT_LSB+:8] = sat8(32'(rx_pkts_i));
      end
      SEL_TXS: begin
        rd_word = txs_q[ctx];
        rd_word[CNT_LSB+:8] = sat8(32'(tx_pkts_i));
        rd_word[TXFULL_BIT] = tx_free_i < tx_max_copy_i;
        rd_word[TXLOW_BIT]  = tx_level_i < tx_mark_i;
      end
      SEL_INFO: begin
        rd_word[CTX_W-1:0] = ctx;
        rd_word[RXB_INFO]  = rx_busy;
        rd_word[TXB_INFO]  = tx_busy;
      end
      default: rd_word = '0;
    endcase
  end

  // per-context storage; bus writes take precedence over completion writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N_CTX); i++) begin
        rxd_q[i] <= '0;
        rxs_q[i] <= '0;
        txd_q[i] <= '0;
        txs_q[i] <= '0;
      end
    end else begin
      if (rx_dn_we_i) rxs_q[rx_dn_ctx_i] <= rx_dn_word_i;
      if (tx_dn_we_i) txs_q[tx_dn_ctx_i] <= tx_dn_word_i;
      if (rx_go) begin
        rxd_q[ctx] <= wdata_i;
        rxs_q[ctx] <= 64'd1 << BUSY_BIT;
      end
      if (tx_go) begin
        txd_q[ctx] <= wdata_i;
        txs_q[ctx] <= 64'd1 << BUSY_BIT;
      end
    end
  end

  // registered response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o     <= 1'b0;
      err_o     <= 1'b0;
      ovf_o     <= 1'b0;
      rdata_o   <= '0;
      rx_kick_o <= 1'b0;
      tx_kick_o <= 1'b0;
    end else begin
      ack_o     <= req_i && !err_c;
      err_o     <= err_c;
      ovf_o     <= (rx_wr && !rx_busy && rx_full) || (tx_wr && !tx_busy && tx_ovf);
      rdata_o   <= (req_i && !we_i && !err_c) ? rd_word : '0;
      rx_kick_o <= rx_go && rx_en_i && rx_idle_i;
      tx_kick_o <= tx_go && tx_en_i && tx_idle_i && (tx_head_mine || !tx_q_vld_o);
    end
  end
endmodule

// File: rtl/nic_ctx_dispatch_chk.sv
module nic_ctx_dispatch_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic ack_o,
  input logic err_o,
  input logic ovf_o,
  input logic rx_kick_o,
  input logic tx_kick_o,
  input logic rx_q_vld_o,
  input logic tx_q_vld_o,
  input logic rx_q_pop_i,
  input logic tx_q_pop_i
);
  a_r1_one_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (ack_o ^ err_o));
  a_r1_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!ack_o && !err_o));
  a_r12_ovf_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> err_o);
  a_r7_kick_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_kick_o |-> (ack_o && rx_q_vld_o));
  a_r8_kick_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_kick_o |-> ack_o);
  a_r8_kick_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_kick_o && !$past(tx_q_pop_i)) |-> tx_q_vld_o);
  a_r11_rx_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_q_vld_o) |-> $past(rx_q_pop_i));
  a_r11_tx_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_q_vld_o) |-> $past(tx_q_pop_i));
endmodule

bind nic_ctx_dispatch nic_ctx_dispatch_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .ack_o     (ack_o),
  .err_o     (err_o),
  .ovf_o     (ovf_o),
  .rx_kick_o (rx_kick_o),
  .tx_kick_o (tx_kick_o),
  .rx_q_vld_o(rx_q_vld_o),
  .tx_q_vld_o(tx_q_vld_o),
  .rx_q_pop_i(rx_q_pop_i),
  .tx_q_pop_i(tx_q_pop_i)
);

// File: tb/test_nic_ctx_dispatch.sv
`timescale 1ns/1ps
module test_nic_ctx_dispatch;
  localparam int AW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0, s8 = 0;
  logic [AW-1:0] addr = '0;
  logic [63:0] wdata = '0;
  logic rx_en = 0, rx_idle = 0, tx_en = 0, tx_idle = 0;
  logic rx_pop = 0, tx_pop = 0;
  logic rx_dn_we = 0, tx_dn_we = 0;
  logic [3:0] rx_dn_ctx = '0, tx_dn_ctx = '0;
  logic [63:0] rx_dn_word = '0, tx_dn_word = '0;
  logic [15:0] rx_pkts = '0, tx_pkts = '0, tx_free = '0, tx_level = '0, tx_maxc = '0, tx_mark = '0;

  logic ack, err, ovf, rx_kick, tx_kick, rx_v, tx_v;
  logic [63:0] rdata, rx_desc, tx_desc;
  logic [3:0] rx_h, tx_h;
  logic s_ack, s_err, s_ovf, s_rxk, s_txk, s_rxv, s_txv;
  logic [63:0] s_rdata, s_rxd, s_txd;
  logic [3:0] s_rxh, s_txh;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  nic_ctx_dispatch i_nic_ctx_dispatch (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size8_i(s8), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .err_o(err), .ovf_o(ovf), .rdata_o(rdata),
    .rx_en_i(rx_en), .rx_idle_i(rx_idle), .tx_en_i(tx_en), .tx_idle_i(tx_idle),
    .rx_kick_o(rx_kick), .tx_kick_o(tx_kick),
    .rx_q_pop_i(rx_pop), .rx_q_vld_o(rx_v), .rx_q_ctx_o(rx_h), .rx_q_desc_o(rx_desc),
    .tx_q_pop_i(tx_pop), .tx_q_vld_o(tx_v), .tx_q_ctx_o(tx_h), .tx_q_desc_o(tx_desc),
    .rx_dn_we_i(rx_dn_we), .rx_dn_ctx_i(rx_dn_ctx), .rx_dn_word_i(rx_dn_word),
    .tx_dn_we_i(tx_dn_we), .tx_dn_ctx_i(tx_dn_ctx), .tx_dn_word_i(tx_dn_word),
    .rx_pkts_i(rx_pkts), .tx_pkts_i(tx_pkts), .tx_free_i(tx_free), .tx_level_i(tx_level),
    .tx_max_copy_i(tx_maxc), .tx_mark_i(tx_mark)
  );

  nic_ctx_dispatch #(.Q_DEPTH(2)) i_nic_ctx_dispatch_shallow (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size8_i(s8), .addr_i(addr),
    .wdata_i(wdata), .ack_o(s_ack), .err_o(s_err), .ovf_o(s_ovf), .rdata_o(s_rdata),
    .rx_en_i(rx_en), .rx_idle_i(rx_idle), .tx_en_i(tx_en), .tx_idle_i(tx_idle),
    .rx_kick_o(s_rxk), .tx_kick_o(s_txk),
    .rx_q_pop_i(rx_pop), .rx_q_vld_o(s_rxv), .rx_q_ctx_o(s_rxh), .rx_q_desc_o(s_rxd),
    .tx_q_pop_i(tx_pop), .tx_q_vld_o(s_txv), .tx_q_ctx_o(s_txh), .tx_q_desc_o(s_txd),
    .rx_dn_we_i(rx_dn_we), .rx_dn_ctx_i(rx_dn_ctx), .rx_dn_word_i(rx_dn_word),
    .tx_dn_we_i(tx_dn_we), .tx_dn_ctx_i(tx_dn_ctx), .tx_dn_word_i(tx_dn_word),
    .rx_pkts_i(rx_pkts), .tx_pkts_i(tx_pkts), .tx_free_i(tx_free), .tx_level_i(tx_level),
    .tx_max_copy_i(tx_maxc), .tx_mark_i(tx_mark)
  );

  task automatic chk(input string req_tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req_tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input int c, input int o, input logic sz8, input logic [63:0] d);
    @(negedge clk);
    req = 1; we = w; s8 = sz8; addr = AW'((c << 6) | o); wdata = d;
    @(negedge clk);
    req = 0; we = 0; wdata = '0;
  endtask

  task automatic rx_popq();
    @(negedge clk); rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  task automatic tx_popq();
    @(negedge clk); tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset ack", 64'(ack), 0);
    chk("R1 reset err", 64'(err), 0);
    chk("R11 reset rx vld", 64'(rx_v), 0);
    chk("R11 reset tx vld", 64'(tx_v), 0);
  endtask

  task automatic t_overflow();
    rx_en = 0;
    bus(1, 10, 'h00, 1, 64'h10);
    bus(1, 11, 'h00, 1, 64'h11);
    bus(1, 12, 'h00, 1, 64'h12);
    chk("R12 shallow err", 64'(s_err), 1);
    chk("R12 shallow ovf", 64'(s_ovf), 1);
    chk("R12 deep ack", 64'(ack), 1);
    chk("R12 deep no ovf", 64'(ovf), 0);
    chk("R12 shallow head kept", 64'(s_rxh), 10);
    rx_pkts = 0;
    bus(0, 12, 'h08, 1, 0);
    chk("R12 shallow ctx12 not busy", s_rdata, 0);
    rx_popq(); rx_popq(); rx_popq();
    chk("R11 deep drained", 64'(rx_v), 0);
  endtask

  task automatic t_decode();
    bus(0, 5, 'h20, 0, 0);
    chk("R1 info ack", 64'(ack), 1);
    chk("R1 info ctx", rdata, 5);
    bus(0, 5, 'h30, 1, 0);
    chk("R2 bad offset", 64'(err), 1);
    bus(0, 5, 'h20, 1, 0);
    chk("R4 size mismatch", 64'(err), 1);
    bus(0, 3, 'h00, 0, 0);
    chk("R4 4-byte desc read", 64'(err), 1);
    bus(1, 4, 'h08, 1, 64'hdead);
    chk("R3 write ro err", 64'(err), 1);
    rx_pkts = 3;
    bus(0, 4, 'h08, 1, 0);
    chk("R3 ro state unchanged", rdata, 64'h0003_0000_0000_0000);
  endtask

  task automatic t_rx();
    rx_en = 1; rx_idle = 1; rx_pkts = 300;
    bus(1, 2, 'h00, 1, 64'ha5);
    chk("R7 kick", 64'(rx_kick), 1);
    chk("R5 ack", 64'(ack), 1);
    bus(0, 2, 'h08, 1, 0);
    chk("R9 rx status busy+sat", rdata, 64'h80ff_0000_0000_0000);
    bus(0, 2, 'h00, 1, 0);
    chk("R5 desc stored", rdata, 64'ha5);
    bus(0, 2, 'h20, 0, 0);
    chk("R1 info busy", rdata, 64'h1_0002);
    chk("R11 head", 64'(rx_h), 2);
    chk("R11 head desc", rx_desc, 64'ha5);
    bus(1, 2, 'h00, 1, 64'hbb);
    chk("R5 busy err", 64'(err), 1);
    rx_idle = 0;
    bus(1, 7, 'h00, 1, 64'h77);
    chk("R7 no kick busy engine", 64'(rx_kick), 0);
    chk("R7 ack", 64'(ack), 1);
    rx_popq();
    chk("R11 fifo order", 64'(rx_h), 7);
    chk("R11 desc follows", rx_desc, 64'h77);
    rx_popq();
    chk("R11 empty", 64'(rx_v), 0);
    @(negedge clk); rx_dn_we = 1; rx_dn_ctx = 2; rx_dn_word = 64'h4000_0000_0000_0040;
    @(negedge clk); rx_dn_we = 0;
    rx_pkts = 3;
    bus(0, 2, 'h08, 1, 0);
    chk("R13 done word", rdata, 64'h4003_0000_0000_0040);
    rx_idle = 1; rx_en = 0;
    bus(1, 2, 'h00, 1, 64'hcc);
    chk("R13 rewrite ok", 64'(ack), 1);
    chk("R7 no kick disabled", 64'(rx_kick), 0);
    rx_popq();
  endtask

  task automatic t_tx();
    tx_en = 1; tx_idle = 1;
    bus(1, 3, 'h10, 1, 64'h33);
    chk("R8 kick first", 64'(tx_kick), 1);
    bus(1, 9, 'h10, 1, 64'h99);
    chk("R8 no kick not head", 64'(tx_kick), 0);
    chk("R11 tx head", 64'(tx_h), 3);
    @(negedge clk); tx_dn_we = 1; tx_dn_ctx = 3; tx_dn_word = 64'h4000_0000_0000_0010;
    @(negedge clk); tx_dn_we = 0;
    bus(1, 3, 'h10, 1, 64'h34);
    chk("R8 kick head same ctx", 64'(tx_kick), 1);
    chk("R6 head desc updated", tx_desc, 64'h34);
    tx_popq();
    chk("R6 next head", 64'(tx_h), 9);
    tx_popq();
    chk("R6 no duplicate entry", 64'(tx_v), 0);
    bus(1, 9, 'h10, 1, 64'h98);
    chk("R6 busy err", 64'(err), 1);
    tx_pkts = 2; tx_free = 10; tx_maxc = 20; tx_level = 5; tx_mark = 4;
    bus(0, 9, 'h18, 1, 0);
    chk("R10 full set low clear", rdata, 64'ha002_0000_0000_0000);
    tx_level = 3; tx_free = 20;
    bus(0, 9, 'h18, 1, 0);
    chk("R10 low set full clear", rdata, 64'h9002_0000_0000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_overflow();
    t_decode();
    t_rx();
    t_tx();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule